// File: doc/BRIEF.md
# ADC Calibration Mode Sequencer

This block owns the operating mode of the digital core of a two-channel sigma-delta converter. Software writes a setup word that carries a 2-bit mode field and a 2-bit filter-select field. A non-normal mode starts a calibration. The block then walks one or two measurement steps on the channel named by the channel-select field. It steers the input multiplexer for each step and stores each step's result in that channel's offset or gain coefficient. When the calibration ends, the mode field drops back to normal on its own.

The modulator and the decimation filter are not part of this block. They appear only as a one-cycle `conv_done` pulse carrying a result word. In normal mode each such result loads the data register. During a calibration step the result becomes a coefficient instead. A `data_wait` flag rises when a calibration is requested. It stays high until a fresh data word has been loaded after the calibration.

Top module: `cal_mode_seq`

## Requirements
- R1: After reset the mode field is 00, the filter field is 01, `data_wait` is 1, `in_mux` is 00, `data_word` is 0, every offset coefficient is 0 and every gain coefficient equals `GAIN_INIT`.
- R2: While no calibration is running, a `setup_wr` strobe loads `wr_filt` into the filter field and `wr_mode` into the mode field. The mode encoding is 00 normal, 01 self-calibration, 10 zero-scale system calibration and 11 full-scale system calibration. Any value other than 00 starts that calibration on the next cycle.
- R3: `data_wait` is 1 in the cycle after a calibration request. It stays 1 through the whole calibration and afterwards. It returns to 0 only after a `conv_done` that arrives in normal mode.
- R4: In normal mode, a `conv_done` pulse loads `conv_result` into `data_word` one cycle later and leaves all coefficients unchanged.
- R5: Self-calibration (mode 01) runs a zero-scale step with `in_mux` = 01 (inputs shorted), then a full-scale step with `in_mux` = 10 (internal reference). The first `conv_done` result goes to the channel's offset and the second to the channel's gain.
- R6: Zero-scale system calibration (mode 10) holds `in_mux` at 00 and waits for one `conv_done`. Its result updates only the selected channel's offset.
- R7: Full-scale system calibration (mode 11) holds `in_mux` at 00 and waits for one `conv_done`. Its result updates only the selected channel's gain.
- R8: In the cycle after the final step's `conv_done`, the mode field reads 00 with no further write.
- R9: The target channel is the low bit of `chan_sel`, sampled on the request cycle. Later changes to `chan_sel` do not move it, and the other channel's coefficients stay unchanged.
- R10: A `setup_wr` strobe that arrives during a calibration changes neither the mode field nor the filter field.
- R11: Results captured during calibration steps never change `data_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_wr | input | 1 | Setup-word write strobe |
| wr_mode | input | 2 | Mode field of the setup write |
| wr_filt | input | 2 | Filter-select field of the setup write |
| chan_sel | input | 2 | Channel-select field from the communications word |
| conv_done | input | 1 | One-cycle pulse: a conversion result is valid |
| conv_result | input | DW | Result word of the finished conversion |
| mode | output | 2 | Current mode field |
| filt_sel | output | 2 | Current filter-select field |
| in_mux | output | 2 | Input steering: 00 external, 01 shorted, 10 reference |
| cal_busy | output | 1 | A calibration step is in progress |
| data_wait | output | 1 | High while no fresh data word is available |
| data_word | output | DW | Data register |
| ofs_all | output | 2*DW | Offset coefficients, channel g at [g*DW +: DW] |
| gain_all | output | 2*DW | Gain coefficients, channel g at [g*DW +: DW] |

## Verification
The in-RTL assertions check the following on every cycle:
- the flag rises after each request and falls only after a normal-mode conversion;
- the mode clears after a final step;
- self-calibration moves from the zero-scale step to the full-scale step;
- writes during a calibration leave the filter field alone;
- a gain-only load does not disturb the offsets;
- the data register is frozen while a step runs.

Only the bench scenarios can show that results go to the correct channel and the correct coefficient, and that the other channel stays untouched. The same holds for the channel being latched at the request, for the step-by-step input steering, and for the reset values.

// File: rtl/cal_seq_pkg.sv
// Shared encodings for the calibration mode sequencer.
package cal_seq_pkg;

    typedef enum logic [1:0] {
        MD_NORM = 2'b00,
        MD_SELF = 2'b01,
        MD_ZSYS = 2'b10,
        MD_FSYS = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ZERO = 2'b01,
        ST_FULL = 2'b10
    } step_e;

    typedef enum logic [1:0] {
        MX_EXT   = 2'b00,
        MX_SHORT = 2'b01,
        MX_VREF  = 2'b10
    } mux_e;

endpackage

// File: rtl/cal_seq_ctrl.sv
// Mode/step controller. It holds the mode and filter fields, steps through
// the calibration, steers the input mux and raises load enables for the
// coefficient bank and the data register.
// Assumes conv_done is a single-cycle pulse and that the setup strobe is
// already synchronous to clk.
module cal_seq_ctrl
    import cal_seq_pkg::*;
#(
    parameter int          CH_W      = 1,
    parameter logic [1:0]  FILT_INIT = 2'b01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            setup_wr,
    input  logic [1:0]      wr_mode,
    input  logic [1:0]      wr_filt,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            conv_done,
    output logic [1:0]      mode_o,
    output logic [1:0]      filt_o,
    output logic [1:0]      mux_o,
    output logic            busy_o,
    output logic [CH_W-1:0] ch_o,
    output logic            ld_ofs_o,
    output logic            ld_gain_o,
    output logic            ld_data_o,
    output logic            wait_o
);

    mode_e            mode_q;
    step_e            step_q;
    logic [1:0]       filt_q;
    logic [CH_W-1:0]  ch_q;
    logic             wait_q;
    logic             idle;
    logic             cal_req;
    logic             last_step;

    assign idle      = (step_q == ST_IDLE);
    assign cal_req   = idle && setup_wr && (wr_mode != MD_NORM);
    assign last_step = !((step_q == ST_ZERO) && (mode_q == MD_SELF));

    // Mode field: accept writes only when idle, clear after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_NORM;
        end else if (idle) begin
            if (setup_wr) mode_q <= mode_e'(wr_mode);
        end else if (conv_done && last_step) begin
            mode_q <= MD_NORM;
        end
    end

    // Filter field: loaded by any write accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)             filt_q <= FILT_INIT;
        else if (idle && setup_wr) filt_q <= wr_filt;
    end

    // Step sequencer: zero-scale before full-scale, one result per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
        end else if (cal_req) begin
            step_q <= (wr_mode == MD_FSYS) ? ST_FULL : ST_ZERO;
        end else if (!idle && conv_done) begin
            step_q <= last_step ? ST_IDLE : ST_FULL;
        end
    end

    // Target channel, sampled once on the request cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ch_q <= '0;
        else if (cal_req) ch_q <= chan_sel;
    end

    // Data-wait flag: set by a request, cleared by a normal-mode result.
    always_ff @(posedge clk) begin
        if (!rst_n)         wait_q <= 1'b1;
        else if (cal_req)   wait_q <= 1'b1;
        else if (ld_data_o) wait_q <= 1'b0;
    end

    // Input steering per step; only self-calibration uses the internal paths.
    always_comb begin
        mux_o = MX_EXT;
        if (mode_q == MD_SELF) begin
            if (step_q == ST_ZERO) mux_o = MX_SHORT;
            if (step_q == ST_FULL) mux_o = MX_VREF;
        end
    end

    assign ld_ofs_o  = (step_q == ST_ZERO) && conv_done;
    assign ld_gain_o = (step_q == ST_FULL) && conv_done;
    assign ld_data_o = idle && conv_done && !cal_req;
    assign mode_o    = mode_q;
    assign filt_o    = filt_q;
    assign busy_o    = !idle;
    assign ch_o      = ch_q;
    assign wait_o    = wait_q;

    // R3: a request is always followed by the flag being high.
    p_flag_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && setup_wr && wr_mode != 2'b00) |=> wait_q);

    // R3: the flag only falls after a normal-mode result.
    p_flag_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_q) |-> $past(conv_done && idle));

    // R8: the final step's result returns the mode to normal.
    p_mode_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && conv_done && last_step) |=> (mode_q == MD_NORM && idle));

    // R5: self-calibration moves from zero-scale to full-scale on the reference.
    p_self_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_ZERO && mode_q == MD_SELF && conv_done)
            |=> (step_q == ST_FULL && mux_o == MX_VREF));

    // R10: a write during calibration leaves the filter field alone.
    p_ignore_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && setup_wr) |=> $stable(filt_q));

endmodule

// File: rtl/cal_coef_bank.sv
// Per-channel offset and gain coefficient registers. One channel is written
// per load enable; the others hold.
// Assumes ld_ofs and ld_gain are never both high in one cycle.
module cal_coef_bank #(
    parameter int           NUM_CH    = 2,
    parameter int           DW        = 16,
    parameter logic [DW-1:0] GAIN_INIT = 16'h8000,
    localparam int          CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_ofs,
    input  logic                 ld_gain,
    input  logic [CH_W-1:0]      ch,
    input  logic [DW-1:0]        val,
    output logic [NUM_CH*DW-1:0] ofs_all,
    output logic [NUM_CH*DW-1:0] gain_all
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [CH_W-1:0] IDX = CH_W'(g);
        logic [DW-1:0] ofs_q;
        logic [DW-1:0] gain_q;

        // Offset of this channel: cleared on reset, loaded by a zero-scale step.
        always_ff @(posedge clk) begin
            if (!rst_n)                    ofs_q <= '0;
            else if (ld_ofs && ch == IDX)  ofs_q <= val;
        end

        // Gain of this channel: nominal on reset, loaded by a full-scale step.
        always_ff @(posedge clk) begin
            if (!rst_n)                    gain_q <= GAIN_INIT;
            else if (ld_gain && ch == IDX) gain_q <= val;
        end

        assign ofs_all[g*DW +: DW]  = ofs_q;
        assign gain_all[g*DW +: DW] = gain_q;
    end

    // R7: a gain load never disturbs any offset.
    p_gain_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_gain && !ld_ofs) |=> $stable(ofs_all));

    // R6: an offset load never disturbs any gain.
    p_ofs_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ofs && !ld_gain) |=> $stable(gain_all));

endmodule

// File: rtl/cal_data_reg.sv
// Conversion data register, loaded with the result of a normal conversion.
// Assumes the load enable is only given in normal mode.
module cal_data_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] val,
    output logic [DW-1:0] data_q
);

    // Hold the latest normal-mode result.
    always_ff @(posedge clk) begin
        if (!rst_n)  data_q <= '0;
        else if (ld) data_q <= val;
    end

endmodule

// File: rtl/cal_mode_seq.sv
// Top of the calibration mode sequencer. It ties the mode controller, the
// coefficient bank and the data register together.
// Assumes a two-bit channel field; only its low CH_W bits address a channel.
module cal_mode_seq #(
    parameter int            NUM_CH    = 2,
    parameter int            DW        = 16,
    parameter logic [DW-1:0] GAIN_INIT = 16'h8000,
    parameter logic [1:0]    FILT_INIT = 2'b01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 setup_wr,
    input  logic [1:0]           wr_mode,
    input  logic [1:0]           wr_filt,
    input  logic [1:0]           chan_sel,
    input  logic                 conv_done,
    input  logic [DW-1:0]        conv_result,
    output logic [1:0]           mode,
    output logic [1:0]           filt_sel,
    output logic [1:0]           in_mux,
    output logic                 cal_busy,
    output logic                 data_wait,
    output logic [DW-1:0]        data_word,
    output logic [NUM_CH*DW-1:0] ofs_all,
    output logic [NUM_CH*DW-1:0] gain_all
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CH_W-1:0] cal_ch;
    logic            ld_ofs;
    logic            ld_gain;
    logic            ld_data;
    logic            unused_chan;

    assign unused_chan = ^chan_sel;

    cal_seq_ctrl #(
        .CH_W      (CH_W),
        .FILT_INIT (FILT_INIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_wr  (setup_wr),
        .wr_mode   (wr_mode),
        .wr_filt   (wr_filt),
        .chan_sel  (chan_sel[CH_W-1:0]),
        .conv_done (conv_done),
        .mode_o    (mode),
        .filt_o    (filt_sel),
        .mux_o     (in_mux),
        .busy_o    (cal_busy),
        .ch_o      (cal_ch),
        .ld_ofs_o  (ld_ofs),
        .ld_gain_o (ld_gain),
        .ld_data_o (ld_data),
        .wait_o    (data_wait)
    );

    cal_coef_bank #(
        .NUM_CH    (NUM_CH),
        .DW        (DW),
        .GAIN_INIT (GAIN_INIT)
    ) u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_ofs   (ld_ofs),
        .ld_gain  (ld_gain),
        .ch       (cal_ch),
        .val      (conv_result),
        .ofs_all  (ofs_all),
        .gain_all (gain_all)
    );

    cal_data_reg #(
        .DW (DW)
    ) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld_data),
        .val    (conv_result),
        .data_q (data_word)
    );

    // R11: the data register is frozen while a calibration step runs.
    p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |=> $stable(data_word));

endmodule

// File: tb/cal_mode_seq_tb.sv
module cal_mode_seq_tb;

    localparam int          DW = 16;
    localparam logic [15:0] GI = 16'h8000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          setup_wr = 1'b0;
    logic [1:0]    wr_mode = 2'b00;
    logic [1:0]    wr_filt = 2'b00;
    logic [1:0]    chan_sel = 2'b00;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_result = '0;
    logic [1:0]    mode, filt_sel, in_mux;
    logic          cal_busy, data_wait;
    logic [DW-1:0] data_word;
    logic [2*DW-1:0] ofs_all, gain_all;

    cal_mode_seq #(.NUM_CH(2), .DW(DW), .GAIN_INIT(GI)) u_dut (
        .clk(clk), .rst_n(rst_n), .setup_wr(setup_wr), .wr_mode(wr_mode),
        .wr_filt(wr_filt), .chan_sel(chan_sel), .conv_done(conv_done),
        .conv_result(conv_result), .mode(mode), .filt_sel(filt_sel),
        .in_mux(in_mux), .cal_busy(cal_busy), .data_wait(data_wait),
        .data_word(data_word), .ofs_all(ofs_all), .gain_all(gain_all)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bench-side model of the expected state.
    logic [1:0]  m_mode = 2'b00;
    logic [1:0]  m_filt = 2'b01;
    int          m_step = 0;
    int          m_ch = 0;
    logic        m_wait = 1'b1;
    logic [15:0] m_data = '0;
    logic [15:0] m_ofs [2] = '{16'h0, 16'h0};
    logic [15:0] m_gain [2] = '{GI, GI};

    typedef struct {
        logic [15:0] data;
        logic [15:0] o0, o1, g0, g1;
        logic [1:0]  md;
        logic        w;
        string       tag;
    } item_t;

    item_t exp_q[$];
    logic  seen_done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mux();
        if (m_step == 1 && m_mode == 2'b01) return 2'b01;
        if (m_step == 2 && m_mode == 2'b01) return 2'b10;
        return 2'b00;
    endfunction

    task automatic chk_ctrl(input string tag);
        chk(mode == m_mode,      {tag, " mode"},  mode, m_mode);
        chk(filt_sel == m_filt,  {tag, " filt"},  filt_sel, m_filt);
        chk(data_wait == m_wait, {tag, " wait"},  data_wait, m_wait);
        chk(in_mux == exp_mux(), {tag, " mux"},   in_mux, exp_mux());
    endtask

    // Driver: one setup write, model updated per R2/R9/R10.
    task automatic setup(input logic [1:0] md, input logic [1:0] f, input logic [1:0] ch);
        if (m_step == 0) begin
            m_filt = f;
            m_mode = md;
            if (md != 2'b00) begin
                m_step = (md == 2'b11) ? 2 : 1;
                m_ch   = int'(ch[0]);
                m_wait = 1'b1;
            end
        end
        @(negedge clk);
        setup_wr = 1'b1; wr_mode = md; wr_filt = f; chan_sel = ch;
        @(negedge clk);
        setup_wr = 1'b0;
    endtask

    // Driver: one conversion result; expected snapshot pushed to the scoreboard.
    task automatic conv(input logic [15:0] v, input string tag);
        item_t it;
        if (m_step == 0) begin
            m_data = v; m_wait = 1'b0;
        end else if (m_step == 1) begin
            m_ofs[m_ch] = v;
            if (m_mode == 2'b01) m_step = 2;
            else begin m_step = 0; m_mode = 2'b00; end
        end else begin
            m_gain[m_ch] = v;
            m_step = 0; m_mode = 2'b00;
        end
        it.data = m_data; it.o0 = m_ofs[0]; it.o1 = m_ofs[1];
        it.g0 = m_gain[0]; it.g1 = m_gain[1]; it.md = m_mode; it.w = m_wait;
        it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        conv_done = 1'b1; conv_result = v;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    always @(posedge clk) seen_done <= conv_done;

    // Monitor: after each result, compare the whole visible state.
    always @(negedge clk) begin
        if (seen_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", 0, 1);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(data_word == it.data,           {it.tag, " data"},  data_word, it.data);
                chk(ofs_all[15:0] == it.o0,         {it.tag, " ofs0"},  ofs_all[15:0], it.o0);
                chk(ofs_all[31:16] == it.o1,        {it.tag, " ofs1"},  ofs_all[31:16], it.o1);
                chk(gain_all[15:0] == it.g0,        {it.tag, " gain0"}, gain_all[15:0], it.g0);
                chk(gain_all[31:16] == it.g1,       {it.tag, " gain1"}, gain_all[31:16], it.g1);
                chk(mode == it.md,                  {it.tag, " mode"},  mode, it.md);
                chk(data_wait == it.w,              {it.tag, " wait"},  data_wait, it.w);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_ctrl("R1");
        chk(data_word == 16'h0,        "R1 data", data_word, 0);
        chk(ofs_all == 32'h0,          "R1 ofs",  ofs_all, 0);
        chk(gain_all == {GI, GI},      "R1 gain", gain_all, {GI, GI});
        chk(cal_busy == 1'b0,          "R1 busy", cal_busy, 0);

        // R4 / R3: normal conversion loads data and clears the flag
        conv(16'h1234, "R4 normal");

        // R2: normal-mode write updates the filter field only
        setup(2'b00, 2'b10, 2'b00);
        chk_ctrl("R2 filt write");

        // R5: self-calibration on channel 1, zero-scale then full-scale
        setup(2'b01, 2'b11, 2'b01);
        chk_ctrl("R5 self zero step");
        chk(cal_busy == 1'b1, "R5 busy", cal_busy, 1);
        @(negedge clk); chan_sel = 2'b00;       // R9: late change ignored
        conv(16'h0011, "R5 self zero");
        chk_ctrl("R5 self full step");
        conv(16'hAAAA, "R5 self full / R8 / R9");
        chk_ctrl("R8 back to normal");
        // R3: flag stays high until a normal-mode word arrives
        chk(data_wait == 1'b1, "R3 wait after cal", data_wait, 1);
        conv(16'h2222, "R3 normal after cal");

        // R6: zero-scale system calibration on channel 0; R10: write ignored
        setup(2'b10, 2'b01, 2'b00);
        chk_ctrl("R6 zsys step");
        setup(2'b11, 2'b00, 2'b01);
        chk_ctrl("R10 write during cal");
        conv(16'h0F0F, "R6 zsys / R11");
        chk_ctrl("R8 after zsys");

        // R7: full-scale system calibration; R9: chan_sel 10 selects channel 0
        setup(2'b11, 2'b01, 2'b10);
        chk_ctrl("R7 fsys step");
        conv(16'h7777, "R7 fsys / R9 low bit");
        conv(16'h3333, "R4 normal again");

        // R7: full-scale on channel 1 via chan_sel 11
        setup(2'b11, 2'b10, 2'b11);
        conv(16'h5A5A, "R7 fsys ch1");
        chk_ctrl("R8 after fsys");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule